// File: doc/BRIEF.md
# Multi-Channel Command Mailbox Responder

This block sits between a host processor and an embedded power-management controller. It exposes several independent mailbox channels. Each channel has one command word and a two-word data window. The host fills the data window, then writes the command word with its run flag set. The command word packs a 7-bit opcode and two byte parameters next to that flag. The controller sees the pending command on a handshake port and answers with a result code and result data. The block then clears the run flag and pulses the channel's interrupt.

A host may wait for the interrupt or simply poll the run flag. A channel built as a narrow channel carries only the low data word in both directions. A per-channel watchdog ends any command the controller never answers and reports a timeout code. When more than one channel is pending, the controller port presents the lowest-numbered one.

Top module: `mbx_responder`

## Requirements
- R1: Command word layout: bit 31 run flag, bits 30:24 opcode, bits 23:16 second parameter, bits 15:8 first parameter, bits 7:0 result code. A host write to an idle channel's command word stores bits 31:8 and clears bits 7:0. The write starts a command when bit 31 is 1. After reset every word reads 0.
- R2: While a channel's run flag reads 1, host writes to its command word are ignored. The command in flight is unchanged and its run flag stays 1 until completion.
- R3: Host word address = {channel, reg}, with reg in the low 2 bits: 0 command word, 2 data low, 3 data high, 1 reads 0. A channel index of NUM_CH or above reads 0 and its writes are ignored.
- R4: A narrow channel (channel 0 by default) keeps its high data word at 0. Host writes to it and controller result data for it are ignored, and ctl_req_hi presents 0 for it.
- R5: Host writes to a channel's data words while its run flag is 1 are ignored.
- R6: ctl_req_valid is 1 when any channel runs. ctl_req_chan is then the lowest running channel, and ctl_req_opcode, ctl_req_p1, ctl_req_p2, ctl_req_lo and ctl_req_hi show that channel's command and input data.
- R7: ctl_rsp_valid while ctl_req_valid completes the presented channel. In the next cycle its run flag reads 0, its result code equals ctl_rsp_code, and its data words hold ctl_rsp_lo and ctl_rsp_hi.
- R8: A channel's irq bit is 1 for exactly one cycle, the first cycle in which the run flag reads 0 after a completion.
- R9: A command still running WDOG_LIMIT cycles after it starts completes by itself with result code 0x03. Its data words are left unchanged and its irq bit pulses.
- R10: Result code values: 0x00 success, 0x01 invalid command, 0x02 invalid parameter, 0x03 timeout, 0x04 locked, 0x05 invalid regulator id, 0x06 regulator error. A controller code is stored verbatim.
- R11: ctl_rsp_valid while no channel runs changes no channel and raises no irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | CHW+2 | Host word address {channel, reg} |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| ctl_req_valid | output | 1 | A command is presented to the controller |
| ctl_req_chan | output | CHW | Presented channel index |
| ctl_req_opcode | output | 7 | Presented opcode |
| ctl_req_p1 | output | 8 | Presented first parameter |
| ctl_req_p2 | output | 8 | Presented second parameter |
| ctl_req_lo | output | 32 | Presented input data low word |
| ctl_req_hi | output | 32 | Presented input data high word |
| ctl_rsp_valid | input | 1 | Controller completes the presented command |
| ctl_rsp_code | input | 8 | Result code |
| ctl_rsp_lo | input | 32 | Result data low word |
| ctl_rsp_hi | input | 32 | Result data high word |
| irq | output | NUM_CH | Per-channel completion pulse |

## Verification
A wrong run flag shows up at once on ctl_req_valid and ctl_req_chan, because a lost or phantom pending command changes the controller-side presentation in the same cycle. A corrupted command word or data word is visible through a host read, or through the ctl_req fields while the command is pending. A watchdog that counts wrongly moves the run-flag fall and the irq pulse away from cycle WDOG_LIMIT, so the bench samples the run flag one cycle before and at that cycle. Mis-routed completions appear in the next cycle as the wrong channel losing its run flag or taking the result code.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int WORD_W  = 32;
    localparam int RUN_BIT = 31;
    localparam int OPC_LSB = 24;
    localparam int OPC_W   = 7;
    localparam int P2_LSB  = 16;
    localparam int P1_LSB  = 8;
    localparam int CODE_W  = 8;

    typedef enum logic [7:0] {
        RC_OK        = 8'h00,
        RC_BAD_CMD   = 8'h01,
        RC_BAD_PARAM = 8'h02,
        RC_TIMEOUT   = 8'h03,
        RC_LOCKED    = 8'h04,
        RC_BAD_VRID  = 8'h05,
        RC_VR_FAULT  = 8'h06
    } rc_e;

    typedef enum logic [1:0] {
        REG_CMD  = 2'd0,
        REG_RSVD = 2'd1,
        REG_DLO  = 2'd2,
        REG_DHI  = 2'd3
    } reg_e;
endpackage

// File: rtl/mbx_host_dec.sv
module mbx_host_dec
    import mbx_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CHW    = 2
) (
    input  logic              host_we,
    input  logic [CHW+1:0]    host_addr,
    output logic [CHW-1:0]    chan_idx,
    output logic              chan_ok,
    output reg_e              reg_sel,
    output logic [NUM_CH-1:0] we_cmd,
    output logic [NUM_CH-1:0] we_lo,
    output logic [NUM_CH-1:0] we_hi
);
    always_comb begin
        chan_idx = host_addr[CHW+1:2];
        reg_sel  = reg_e'(host_addr[1:0]);
        chan_ok  = (int'(chan_idx) < NUM_CH);
        we_cmd   = '0;
        we_lo    = '0;
        we_hi    = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (host_we && chan_ok && (int'(chan_idx) == k)) begin
                we_cmd[k] = (reg_sel == REG_CMD);
                we_lo[k]  = (reg_sel == REG_DLO);
                we_hi[k]  = (reg_sel == REG_DHI);
            end
        end
    end

    always_comb begin
        AST_ONE_STROBE: assert ($onehot0({we_cmd, we_lo, we_hi})); // R3
    end
endmodule

// File: rtl/mbx_prio_sel.sv
module mbx_prio_sel #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) idx = IW'(k);
        end
    end

    AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (req[idx] && ((req & ~({N{1'b1}} << idx)) == '0))); // R6
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
#(
    parameter int WDOG_LIMIT = 64,
    parameter bit WIDE       = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_cmd,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [WORD_W-1:0] wdata,
    input  logic              take,
    input  logic [CODE_W-1:0] rsp_code,
    input  logic [WORD_W-1:0] rsp_lo,
    input  logic [WORD_W-1:0] rsp_hi,
    output logic [WORD_W-1:0] cmd_o,
    output logic [WORD_W-1:0] lo_o,
    output logic [WORD_W-1:0] hi_o,
    output logic              run_o,
    output logic              irq_o
);
    localparam int CW = $clog2(WDOG_LIMIT + 1);

    typedef struct packed {
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
        logic [CW-1:0]     cnt;
        logic              irq;
    } ch_st_t;

    ch_st_t s_d, s_q;
    logic   expire;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        expire  = s_q.cmd[RUN_BIT] && (s_q.cnt == CW'(WDOG_LIMIT - 1));
        if (s_q.cmd[RUN_BIT]) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (take) begin
                s_d.cmd[RUN_BIT]    = 1'b0;
                s_d.cmd[CODE_W-1:0] = rsp_code;
                s_d.lo              = rsp_lo;
                if (WIDE) s_d.hi = rsp_hi;
                s_d.irq             = 1'b1;
                s_d.cnt             = '0;
            end else if (expire) begin
                s_d.cmd[RUN_BIT]    = 1'b0;
                s_d.cmd[CODE_W-1:0] = RC_TIMEOUT;
                s_d.irq             = 1'b1;
                s_d.cnt             = '0;
            end
        end else begin
            if (we_cmd) begin
                s_d.cmd = {wdata[WORD_W-1:CODE_W], {CODE_W{1'b0}}};
                s_d.cnt = '0;
            end
            if (we_lo) s_d.lo = wdata;
            if (we_hi && WIDE) s_d.hi = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_o = s_q.cmd;
    assign lo_o  = s_q.lo;
    assign hi_o  = s_q.hi;
    assign run_o = s_q.cmd[RUN_BIT];
    assign irq_o = s_q.irq;

    AST_BUSY_CMD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cmd[RUN_BIT] && we_cmd && !take && !expire)
        |=> (s_q.cmd[RUN_BIT] && $stable(s_q.cmd[WORD_W-2:CODE_W]))); // R2

    AST_BUSY_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cmd[RUN_BIT] && !take && !expire) |=> ($stable(s_q.lo) && $stable(s_q.hi))); // R5

    AST_NARROW_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !WIDE |-> (s_q.hi == '0)); // R4

    AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.cmd[RUN_BIT]) |-> s_q.irq); // R8

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |=> !s_q.irq); // R8

    AST_WDOG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cmd[RUN_BIT] |-> (int'(s_q.cnt) < WDOG_LIMIT)); // R9

    AST_TIMEOUT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cmd[RUN_BIT] && !take && (int'(s_q.cnt) == WDOG_LIMIT - 1))
        |=> (!s_q.cmd[RUN_BIT] && s_q.cmd[CODE_W-1:0] == RC_TIMEOUT)); // R9

    AST_CODE_VERBATIM: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cmd[RUN_BIT] && take) |=> (s_q.cmd[CODE_W-1:0] == $past(rsp_code))); // R10
endmodule

// File: rtl/mbx_responder.sv
module mbx_responder
    import mbx_pkg::*;
#(
    parameter int          NUM_CH     = 3,
    parameter int          WDOG_LIMIT = 64,
    parameter logic [NUM_CH-1:0] WIDE_MASK = 3'b110,
    localparam int         CHW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [CHW+1:0]    host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              ctl_req_valid,
    output logic [CHW-1:0]    ctl_req_chan,
    output logic [6:0]        ctl_req_opcode,
    output logic [7:0]        ctl_req_p1,
    output logic [7:0]        ctl_req_p2,
    output logic [31:0]       ctl_req_lo,
    output logic [31:0]       ctl_req_hi,
    input  logic              ctl_rsp_valid,
    input  logic [7:0]        ctl_rsp_code,
    input  logic [31:0]       ctl_rsp_lo,
    input  logic [31:0]       ctl_rsp_hi,
    output logic [NUM_CH-1:0] irq
);
    logic [CHW-1:0]    dec_chan;
    logic              dec_ok;
    reg_e              dec_reg;
    logic [NUM_CH-1:0] we_cmd, we_lo, we_hi;
    logic [NUM_CH-1:0] run_vec;
    logic [NUM_CH-1:0] take_vec;
    logic              sel_any;
    logic [CHW-1:0]    sel_idx;
    logic [31:0]       cmd_w [NUM_CH];
    logic [31:0]       lo_w  [NUM_CH];
    logic [31:0]       hi_w  [NUM_CH];

    mbx_host_dec #(.NUM_CH(NUM_CH), .CHW(CHW)) u_dec (
        .host_we  (host_we),
        .host_addr(host_addr),
        .chan_idx (dec_chan),
        .chan_ok  (dec_ok),
        .reg_sel  (dec_reg),
        .we_cmd   (we_cmd),
        .we_lo    (we_lo),
        .we_hi    (we_hi)
    );

    mbx_prio_sel #(.N(NUM_CH), .IW(CHW)) u_sel (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (run_vec),
        .any  (sel_any),
        .idx  (sel_idx)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign take_vec[g] = ctl_rsp_valid && sel_any && (int'(sel_idx) == g);

        mbx_channel #(.WDOG_LIMIT(WDOG_LIMIT), .WIDE(WIDE_MASK[g])) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_cmd  (we_cmd[g]),
            .we_lo   (we_lo[g]),
            .we_hi   (we_hi[g]),
            .wdata   (host_wdata),
            .take    (take_vec[g]),
            .rsp_code(ctl_rsp_code),
            .rsp_lo  (ctl_rsp_lo),
            .rsp_hi  (ctl_rsp_hi),
            .cmd_o   (cmd_w[g]),
            .lo_o    (lo_w[g]),
            .hi_o    (hi_w[g]),
            .run_o   (run_vec[g]),
            .irq_o   (irq[g])
        );
    end

    always_comb begin
        host_rdata = '0;
        if (dec_ok) begin
            case (dec_reg)
                REG_CMD: host_rdata = cmd_w[dec_chan];
                REG_DLO: host_rdata = lo_w[dec_chan];
                REG_DHI: host_rdata = hi_w[dec_chan];
                default: host_rdata = '0;
            endcase
        end
    end

    always_comb begin
        ctl_req_valid  = sel_any;
        ctl_req_chan   = sel_idx;
        ctl_req_opcode = '0;
        ctl_req_p1     = '0;
        ctl_req_p2     = '0;
        ctl_req_lo     = '0;
        ctl_req_hi     = '0;
        if (sel_any) begin
            ctl_req_opcode = cmd_w[sel_idx][OPC_LSB +: OPC_W];
            ctl_req_p1     = cmd_w[sel_idx][P1_LSB +: 8];
            ctl_req_p2     = cmd_w[sel_idx][P2_LSB +: 8];
            ctl_req_lo     = lo_w[sel_idx];
            ctl_req_hi     = hi_w[sel_idx];
        end
    end

    AST_ORPHAN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rsp_valid && !ctl_req_valid) |=> (irq == '0)); // R11

    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_vec)); // R7
endmodule

// File: tb/mbx_responder_tb.sv
module mbx_responder_tb;
    localparam int NUM_CH = 3;
    localparam int LIMIT  = 24;
    localparam int CHW    = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        ctl_req_valid;
    logic [1:0]  ctl_req_chan;
    logic [6:0]  ctl_req_opcode;
    logic [7:0]  ctl_req_p1, ctl_req_p2;
    logic [31:0] ctl_req_lo, ctl_req_hi;
    logic        ctl_rsp_valid = 1'b0;
    logic [7:0]  ctl_rsp_code = '0;
    logic [31:0] ctl_rsp_lo = '0, ctl_rsp_hi = '0;
    logic [2:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mbx_responder #(.NUM_CH(NUM_CH), .WDOG_LIMIT(LIMIT), .WIDE_MASK(3'b110)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .ctl_req_valid(ctl_req_valid), .ctl_req_chan(ctl_req_chan),
        .ctl_req_opcode(ctl_req_opcode), .ctl_req_p1(ctl_req_p1), .ctl_req_p2(ctl_req_p2),
        .ctl_req_lo(ctl_req_lo), .ctl_req_hi(ctl_req_hi),
        .ctl_rsp_valid(ctl_rsp_valid), .ctl_rsp_code(ctl_rsp_code),
        .ctl_rsp_lo(ctl_rsp_lo), .ctl_rsp_hi(ctl_rsp_hi),
        .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] adr(int ch, int r);
        return {2'(ch), 2'(r)};
    endfunction

    function automatic logic [31:0] cmdw(bit run, logic [6:0] op, logic [7:0] p2,
                                         logic [7:0] p1, logic [7:0] code);
        return {run, op, p2, p1, code};
    endfunction

    task automatic hwr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hrd(logic [3:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic rsp(logic [7:0] code, logic [31:0] lo, logic [31:0] hi);
        @(negedge clk);
        ctl_rsp_valid = 1'b1; ctl_rsp_code = code; ctl_rsp_lo = lo; ctl_rsp_hi = hi;
        @(negedge clk);
        ctl_rsp_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int c = 0; c < NUM_CH; c++) begin
            hrd(adr(c, 0), v); chk("R1 reset cmd", v, 0);
            hrd(adr(c, 2), v); chk("R1 reset lo", v, 0);
        end
        chk("R6 reset req_valid", 32'(ctl_req_valid), 0);
        chk("R8 reset irq", 32'(irq), 0);
    endtask

    task automatic t_wide_cmd();
        logic [31:0] v;
        hwr(adr(1, 2), 32'hA0A0_0001);
        hwr(adr(1, 3), 32'hB0B0_0002);
        hwr(adr(1, 0), cmdw(1, 7'h12, 8'hAB, 8'hCD, 8'hFF));
        hrd(adr(1, 0), v); chk("R1 start cmd word", v, 32'h92AB_CD00);
        chk("R6 req_valid", 32'(ctl_req_valid), 1);
        chk("R6 req_chan", 32'(ctl_req_chan), 1);
        chk("R6 opcode", 32'(ctl_req_opcode), 32'h12);
        chk("R6 p1", 32'(ctl_req_p1), 32'hCD);
        chk("R6 p2", 32'(ctl_req_p2), 32'hAB);
        chk("R6 lo", ctl_req_lo, 32'hA0A0_0001);
        chk("R6 hi", ctl_req_hi, 32'hB0B0_0002);
        hwr(adr(1, 0), cmdw(1, 7'h7F, 8'h11, 8'h22, 8'h00));
        hrd(adr(1, 0), v); chk("R2 busy cmd write ignored", v, 32'h92AB_CD00);
        hwr(adr(1, 0), 32'h0);
        hrd(adr(1, 0), v); chk("R2 run flag kept", v, 32'h92AB_CD00);
        hwr(adr(1, 2), 32'hDEAD_BEEF);
        chk("R5 busy lo write ignored", ctl_req_lo, 32'hA0A0_0001);
        chk("R8 no irq while busy", 32'(irq), 0);
        rsp(8'h00, 32'h1111_1111, 32'h2222_2222);
        hrd(adr(1, 0), v); chk("R7 run cleared", v, 32'h12AB_CD00);
        chk("R8 irq pulse", 32'(irq), 32'b010);
        chk("R6 idle after done", 32'(ctl_req_valid), 0);
        hrd(adr(1, 2), v); chk("R7 lo result", v, 32'h1111_1111);
        hrd(adr(1, 3), v); chk("R7 hi result", v, 32'h2222_2222);
        @(negedge clk);
        chk("R8 irq one cycle", 32'(irq), 0);
    endtask

    task automatic t_narrow();
        logic [31:0] v;
        hwr(adr(0, 3), 32'hDEAD_0000);
        hrd(adr(0, 3), v); chk("R4 narrow hi write ignored", v, 0);
        hwr(adr(0, 2), 32'h0000_0777);
        hwr(adr(0, 0), cmdw(1, 7'h01, 8'h02, 8'h03, 8'h00));
        chk("R4 req_hi zero", ctl_req_hi, 0);
        chk("R6 narrow lo", ctl_req_lo, 32'h0000_0777);
        rsp(8'h05, 32'h0000_5A5A, 32'h5555_5555);
        hrd(adr(0, 0), v); chk("R10 code invalid vr id", v, 32'h0102_0305);
        hrd(adr(0, 3), v); chk("R4 narrow hi result ignored", v, 0);
        hrd(adr(0, 2), v); chk("R7 narrow lo result", v, 32'h0000_5A5A);
        chk("R8 irq ch0", 32'(irq), 32'b001);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        hwr(adr(2, 0), cmdw(1, 7'h22, 8'h00, 8'h00, 8'h00));
        chk("R6 single pending ch2", 32'(ctl_req_chan), 2);
        hwr(adr(1, 0), cmdw(1, 7'h21, 8'h00, 8'h00, 8'h00));
        chk("R6 lowest first", 32'(ctl_req_chan), 1);
        chk("R6 lowest opcode", 32'(ctl_req_opcode), 32'h21);
        rsp(8'h02, 32'h0, 32'h0);
        hrd(adr(1, 0), v); chk("R10 code bad param", v, 32'h2100_0002);
        hrd(adr(2, 0), v); chk("R7 other channel still runs", v, 32'hA200_0000);
        chk("R6 next channel", 32'(ctl_req_chan), 2);
        chk("R8 irq only ch1", 32'(irq), 32'b010);
        rsp(8'h00, 32'h0000_00C2, 32'h0000_00D2);
        hrd(adr(2, 2), v); chk("R7 ch2 lo", v, 32'h0000_00C2);
        chk("R6 none pending", 32'(ctl_req_valid), 0);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        hwr(adr(2, 2), 32'h0BAD_0001);
        hwr(adr(2, 0), cmdw(1, 7'h33, 8'h44, 8'h55, 8'h00));
        repeat (LIMIT - 1) @(negedge clk);
        hrd(adr(2, 0), v); chk("R9 still running before limit", v, 32'hB344_5500);
        chk("R9 no early irq", 32'(irq), 0);
        @(negedge clk);
        hrd(adr(2, 0), v); chk("R9 timeout code", v, 32'h3344_5503);
        chk("R9 timeout irq", 32'(irq), 32'b100);
        hrd(adr(2, 2), v); chk("R9 data unchanged", v, 32'h0BAD_0001);
        @(negedge clk);
        chk("R8 timeout irq one cycle", 32'(irq), 0);
    endtask

    task automatic t_orphan_and_map();
        logic [31:0] v;
        rsp(8'h04, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        hrd(adr(1, 0), v); chk("R11 orphan no change", v, 32'h2100_0002);
        hrd(adr(1, 2), v); chk("R11 orphan lo kept", v, 32'h0);
        chk("R11 orphan no irq", 32'(irq), 0);
        hrd(adr(1, 1), v); chk("R3 reserved reads zero", v, 0);
        hwr(adr(3, 0), 32'h8000_0000);
        hrd(adr(3, 0), v); chk("R3 absent channel reads zero", v, 0);
        chk("R3 absent channel not pending", 32'(ctl_req_valid), 0);
        hwr(adr(1, 0), cmdw(0, 7'h0A, 8'h0B, 8'h0C, 8'hEE));
        hrd(adr(1, 0), v); chk("R1 idle write no start", v, 32'h0A0B_0C00);
        chk("R1 no start", 32'(ctl_req_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wide_cmd();
        t_narrow();
        t_prio();
        t_timeout();
        t_orphan_and_map();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R7 watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule